// File: doc/BRIEF.md
# SPI Master Clock and Frame Engine

This block is the serial core of an SPI master. It keeps eight attribute sets; every frame picks one of them. A set gives the frame length, the SCK polarity and phase, the bit order and the SCK divide ratio. From the system clock the engine derives SCK, drives `mosi`, samples `miso` and drives an active-low chip-select bus. A start strobe begins a frame. The parallel transmit word, the attribute fields and the chip-select patterns are latched at that strobe. A one-cycle `done` pulse ends the frame and carries the received word.

The divide ratio is a prescaler times a scaler. A double-rate bit halves that ratio. This makes divide-by-2 and odd ratios reachable, and for odd ratios the SCK high and low times differ. In split mode the frame is always 32 bits long. The frame-size code then marks the bit after which chip-select control moves from a first pattern to a second pattern.

Top module: `spi_frame_engine`

## Requirements
- R1: Writing `cfg_wdata` with `cfg_we` high stores it into attribute set `cfg_sel`. The set layout is: bit 31 double-rate, bits 30:27 size code F, bit 26 polarity, bit 25 phase, bit 24 LSB-first, bits 17:16 prescaler code, bits 3:0 scaler code. Every set resets to 32'h3800_0000 (F=7, all other fields zero).
- R2: The prescaler codes 0..3 give the factors 2, 3, 5 and 7. A scaler code c below 4 gives 2*(c+1), and any other code gives 2^c. The bit period P is prescaler*scaler, halved when the double-rate bit is set. A frame of N bits keeps `busy` high for exactly N*P cycles.
- R3: Each bit has a first half of floor(P/2) cycles followed by a second half of P-floor(P/2) cycles. SCK sits at its active (non-idle) level for the second half when phase=0 and for the first half when phase=1. With double rate and an odd P, the duty cycle is therefore uneven.
- R4: While idle, SCK equals the polarity bit of the set chosen by `attr_sel`. During a frame, SCK is polarity XOR phase in the first half of each bit and the inverse in the second half.
- R5: A normal frame has F+1 bits. `mosi` changes only at bit starts. `miso` is sampled at the first-half to second-half SCK edge. When the frame ends, `rx_word` holds the received bits at the positions of the matching transmit bits, and the bits above the frame are zero.
- R6: With LSB-first clear, transmit bit N-1 is sent first, down to bit 0. With it set, bit 0 is sent first.
- R7: When `split_en` is high at start, the frame has 32 bits. `cs_n` is ~`cs_pat_a` for bits 0..F and ~`cs_pat_b` for the remaining bits. In normal mode, `cs_n` is ~`cs_pat_a` for the whole frame.
- R8: `cfg_err` is high when the selected set has F<3, or when P is 3 or less while `cont_clk` or `mod_timing` is high. A start while `cfg_err` is high is ignored.
- R9: `done` is high for one cycle, in the cycle after the last busy cycle. A start while busy has no effect on the frame in progress.
- R10: While idle, `cs_n` is all ones and `mosi` is 0. After reset, `busy`, `done` and `rx_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Attribute set write strobe |
| cfg_sel | input | 3 | Attribute set written |
| cfg_wdata | input | 32 | Attribute set write data |
| attr_sel | input | 3 | Attribute set used by the next frame |
| split_en | input | 1 | Split chip-select mode for the next frame |
| cont_clk | input | 1 | Continuous-clock option in use (rate check) |
| mod_timing | input | 1 | Modified-timing option in use (rate check) |
| cs_pat_a | input | 8 | First chip-select pattern |
| cs_pat_b | input | 8 | Second chip-select pattern |
| tx_word | input | 32 | Transmit word |
| start | input | 1 | Frame start strobe |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 8 | Active-low chip selects |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame complete pulse |
| rx_word | output | 32 | Received word |
| cfg_err | output | 1 | Selected configuration is illegal |

## Verification
Each test frame uses a different attribute set. Across the sets, the divide ratios include even ratios, odd ratios made by the double-rate bit, and a large ratio. Both polarities and phases, both bit orders and normal and split modes all appear, and frame lengths run from 4 to 32 bits. The bench counts busy cycles to check the period formula. It counts active-level cycles to tell the phase-dependent duty of odd ratios apart from the even case. It records `mosi` and `cs_n` at each sampling edge to tell bit order and the chip-select crossover apart from data. `miso` is either looped back or inverted, so that `rx_word` shows the capture position. Directed cases cover the reset-value set, illegal size codes, fast ratios combined with the timing options, idle SCK level and restarts during a frame.

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int NSET = 8,
  parameter int DW   = 32,
  parameter int CSW  = 8,
  parameter int CW   = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [$clog2(NSET)-1:0] cfg_sel,
  input  logic [31:0]             cfg_wdata,
  input  logic [$clog2(NSET)-1:0] attr_sel,
  input  logic                    split_en,
  input  logic                    cont_clk,
  input  logic                    mod_timing,
  input  logic [CSW-1:0]          cs_pat_a,
  input  logic [CSW-1:0]          cs_pat_b,
  input  logic [DW-1:0]           tx_word,
  input  logic                    start,
  input  logic                    miso,
  output logic                    sck,
  output logic                    mosi,
  output logic [CSW-1:0]          cs_n,
  output logic                    busy,
  output logic                    done,
  output logic [DW-1:0]           rx_word,
  output logic                    cfg_err
);
  localparam int IW = $clog2(DW);
  localparam logic [31:0] ATTR_RST = 32'h3800_0000;

  function automatic logic [CW-1:0] period_of(input logic [31:0] a);
    logic [CW-1:0] pre, sc, full;
    case (a[17:16])
      2'd0:    pre = CW'(2);
      2'd1:    pre = CW'(3);
      2'd2:    pre = CW'(5);
      default: pre = CW'(7);
    endcase
    sc   = (a[3:0] < 4'd4) ? CW'({a[3:0], 1'b0}) + CW'(2) : CW'(1) << a[3:0];
    full = pre * sc;
    return a[31] ? full >> 1 : full;
  endfunction

  logic [31:0] attr [NSET];

  for (genvar g = 0; g < NSET; g++) begin : g_set
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) attr[g] <= ATTR_RST;
      else if (cfg_we && cfg_sel == g) attr[g] <= cfg_wdata;
  end

  logic [31:0]   s_attr;
  logic [3:0]    s_fsz;
  logic [CW-1:0] s_per;
  assign s_attr  = attr[attr_sel];
  assign s_fsz   = s_attr[30:27];
  assign s_per   = period_of(s_attr);
  assign cfg_err = (s_fsz < 4'd3) || ((s_per <= CW'(3)) && (cont_clk || mod_timing));

  logic          active, half, l_cpol, l_cpha, l_lsb, l_split;
  logic [CW-1:0] cnt, l_per;
  logic [IW-1:0] bitn, l_last, idx;
  logic [3:0]    l_fsz;
  logic [CSW-1:0] l_csa, l_csb;
  logic [DW-1:0] tx_l, rx_acc;

  assign idx  = l_lsb ? bitn : l_last - bitn;
  assign busy = active;
  assign sck  = active ? (l_cpol ^ l_cpha ^ half) : s_attr[26];
  assign mosi = active && tx_l[idx];
  assign cs_n = !active ? '1 : ~((l_split && bitn > IW'(l_fsz)) ? l_csb : l_csa);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; half <= 1'b0; done <= 1'b0;
      cnt <= '0; l_per <= '0; bitn <= '0; l_last <= '0; l_fsz <= '0;
      l_cpol <= 1'b0; l_cpha <= 1'b0; l_lsb <= 1'b0; l_split <= 1'b0;
      l_csa <= '0; l_csb <= '0; tx_l <= '0; rx_acc <= '0; rx_word <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start && !cfg_err) begin
          active  <= 1'b1;
          half    <= 1'b0;
          cnt     <= (s_per >> 1) - CW'(1);
          l_per   <= s_per;
          bitn    <= '0;
          l_fsz   <= s_fsz;
          l_last  <= split_en ? IW'(DW - 1) : IW'(s_fsz);
          l_cpol  <= s_attr[26];
          l_cpha  <= s_attr[25];
          l_lsb   <= s_attr[24];
          l_split <= split_en;
          l_csa   <= cs_pat_a;
          l_csb   <= cs_pat_b;
          tx_l    <= tx_word;
          rx_acc  <= '0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - CW'(1);
      end else if (!half) begin
        half        <= 1'b1;
        cnt         <= l_per - (l_per >> 1) - CW'(1);
        rx_acc[idx] <= miso;
      end else if (bitn == l_last) begin
        active  <= 1'b0;
        done    <= 1'b1;
        rx_word <= rx_acc;
      end else begin
        bitn <= bitn + IW'(1);
        half <= 1'b0;
        cnt  <= (l_per >> 1) - CW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_frame_engine_chk.sv
module spi_frame_engine_chk #(
  parameter int CSW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           cfg_err,
  input logic           mosi,
  input logic [CSW-1:0] cs_n
);
  p_cs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> &cs_n);
  p_mosi_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);
  p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && cfg_err) |=> !busy);
  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_start_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind spi_frame_engine spi_frame_engine_chk #(.CSW(CSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cfg_err(cfg_err), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/spi_frame_engine_test.sv
module spi_frame_engine_test;
  localparam int TCLK = 10;
  localparam logic [7:0] PA = 8'hA5;
  localparam logic [7:0] PB = 8'h3C;
  // {attr, tx, invert miso, split}
  localparam logic [65:0] VEC [0:6] = '{
    {32'h3800_0000, 32'h0000_00A5, 1'b0, 1'b0},
    {32'h7F01_0001, 32'h0000_C3E1, 1'b1, 1'b0},
    {32'h9801_0000, 32'h0000_000B, 1'b0, 1'b0},
    {32'hCA02_0001, 32'h0000_0265, 1'b1, 1'b0},
    {32'h2800_0000, 32'hDEAD_BEEF, 1'b0, 1'b1},
    {32'hDF03_0000, 32'h0000_0A3C, 1'b0, 1'b0},
    {32'h1800_0004, 32'h0000_0009, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, split_en = 1'b0, cont_clk = 1'b0, mod_timing = 1'b0, start = 1'b0;
  logic [2:0] cfg_sel = '0, attr_sel = '0;
  logic [31:0] cfg_wdata = '0, tx_word = '0;
  logic inv = 1'b0;
  logic miso, sck, mosi, busy, done, cfg_err;
  logic [7:0] cs_n;
  logic [31:0] rx_word;
  int nchk = 0, nfail = 0, cyc = 0;

  assign miso = mosi ^ inv;
  always #(TCLK/2) clk = ~clk;

  spi_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .attr_sel(attr_sel), .split_en(split_en), .cont_clk(cont_clk), .mod_timing(mod_timing),
    .cs_pat_a(PA), .cs_pat_b(PB), .tx_word(tx_word), .start(start), .miso(miso),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done), .rx_word(rx_word),
    .cfg_err(cfg_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int period(input logic [31:0] a);
    int pre, sc;
    pre = (a[17:16] == 0) ? 2 : (a[17:16] == 1) ? 3 : (a[17:16] == 2) ? 5 : 7;
    sc  = (a[3:0] < 4) ? 2 * (a[3:0] + 1) : (1 << a[3:0]);
    return a[31] ? pre * sc / 2 : pre * sc;
  endfunction

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic run(input logic [2:0] s, input logic [31:0] a, input logic [31:0] tx,
                     input logic iv, input logic sp);
    int p, n, nb, nact, ncap, obad, cbad, fz;
    logic cpol, cpha, lsb, prev, first_sck;
    logic [63:0] mask;
    p = period(a); fz = a[30:27]; n = sp ? 32 : fz + 1;
    cpol = a[26]; cpha = a[25]; lsb = a[24];
    nb = 0; nact = 0; ncap = 0; obad = 0; cbad = 0; first_sck = 1'b0;
    @(negedge clk);
    attr_sel = s; tx_word = tx; inv = iv; split_en = sp; start = 1'b1;
    @(negedge clk); start = 1'b0;
    prev = cpol;
    for (int k = 0; k < 20000 && !done; k++) begin
      if (busy) begin
        if (nb == 0) first_sck = sck;
        nb++;
        if (sck != cpol) nact++;
        if (sck != prev && sck == (cpha ? cpol : !cpol)) begin
          if (mosi !== tx[lsb ? ncap : n - 1 - ncap]) obad++;
          if (cs_n !== ((sp && ncap > fz) ? ~PB : ~PA)) cbad++;
          ncap++;
        end
        prev = sck;
      end
      if (k == 7) start = 1'b1;
      if (k == 8) start = 1'b0;
      @(negedge clk);
    end
    mask = (64'd1 << n) - 64'd1;
    check("R9 done seen", {31'd0, done}, 32'd1);
    check("R2 busy cycles", nb, n * p);
    check("R3 active-level cycles", nact, n * (cpha ? p / 2 : p - p / 2));
    check("R4 first SCK level", {31'd0, first_sck}, {31'd0, cpol ^ cpha});
    check("R5 sample edges", ncap, n);
    check("R6 bit order", obad, 0);
    check("R7 chip selects", cbad, 0);
    check("R5 rx word", rx_word, (iv ? ~tx : tx) & mask[31:0]);
    @(negedge clk);
    check("R9 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 busy at reset", {31'd0, busy}, 32'd0);
    check("R10 done at reset", {31'd0, done}, 32'd0);
    check("R10 cs_n at reset", {24'd0, cs_n}, 32'hFF);
    check("R10 mosi at reset", {31'd0, mosi}, 32'd0);
    check("R10 rx at reset", rx_word, 32'd0);
    check("R4 idle sck at reset", {31'd0, sck}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: set 7 never written keeps its reset contents
    run(3'd7, 32'h3800_0000, 32'h0000_005A, 1'b0, 1'b0);

    for (int i = 0; i < 7; i++) begin
      wr(3'(i), VEC[i][65:34]);
      run(3'(i), VEC[i][65:34], VEC[i][33:2], VEC[i][1], VEC[i][0]);
    end

    // R4: idle sck follows the polarity of the selected set
    @(negedge clk); attr_sel = 3'd1;
    @(negedge clk); check("R4 idle sck high", {31'd0, sck}, 32'd1);
    attr_sel = 3'd0;
    @(negedge clk); check("R4 idle sck low", {31'd0, sck}, 32'd0);

    // R8: illegal size code rejected
    wr(3'd2, 32'h1000_0000);
    @(negedge clk); attr_sel = 3'd2;
    @(negedge clk); check("R8 size error", {31'd0, cfg_err}, 32'd1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check("R8 start ignored on size error", {31'd0, busy}, 32'd0);
    @(negedge clk); check("R8 no done on size error", {31'd0, done}, 32'd0);

    // R8: divide-by-3 with continuous clock
    wr(3'd3, 32'h9801_0000);
    @(negedge clk); attr_sel = 3'd3; cont_clk = 1'b1;
    @(negedge clk); check("R8 rate error", {31'd0, cfg_err}, 32'd1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check("R8 start ignored on rate error", {31'd0, busy}, 32'd0);
    cont_clk = 1'b0;
    @(negedge clk); check("R8 divide-by-3 alone legal", {31'd0, cfg_err}, 32'd0);
    mod_timing = 1'b1;
    @(negedge clk); check("R8 rate error modified timing", {31'd0, cfg_err}, 32'd1);
    attr_sel = 3'd0;
    @(negedge clk); check("R8 divide-by-4 with option legal", {31'd0, cfg_err}, 32'd0);
    mod_timing = 1'b0;

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule